// File: doc/BRIEF.md
# Reservation Monitor for Load-Reserve / Store-Conditional Atomics

This block keeps the reservation state behind an atomic read-modify-write sequence built from a load-reserve followed by a store-conditional. The core it serves runs several hardware threads. Each thread has exactly one reservation slot. A slot records one cache line of 128 bytes, so two addresses belong to the same line when they agree in every bit from bit 7 upward. Every cycle the block accepts at most one memory request and one eviction notice from the cache. The request carries an operation code, a thread number and a byte address.

A store-conditional succeeds only when the issuing thread still holds an intact reservation on the line it targets. The block decides this in the same cycle as the request and drives the memory write enable straight away. One cycle later it reports a pass/fail flag and a 4-bit condition field. A reservation can be lost in three ways: the line is evicted, another thread stores to the line, or the owning thread issues any store-conditional. Because of this, a store-conditional can fail even when the data in memory is the same as before. The cache, the data array, barriers and the rest of the pipeline are outside this block.

Top module: `lrsc_monitor`

## Requirements
- R1: After a synchronous active-low reset, no thread holds a reservation, `res_valid` is low, and the first store-conditional from any thread fails.
- R2: A load-reserve (`req_op`=1) sets the thread's reservation on the 128-byte line of `req_addr`. A later store-conditional (`req_op`=2) from the same thread to any byte of that line passes, and `wr_grant` is high in the same cycle as the request.
- R3: A store-conditional whose address differs from the reserved address in any bit from bit 7 upward fails, and `wr_grant` stays low.
- R4: Every store-conditional, whether it passes or fails, removes the issuing thread's reservation.
- R5: A plain store (`req_op`=3) or a store-conditional from another thread to a reserved line removes the reservation. A plain store from the owning thread leaves its own reservation in place.
- R6: An eviction notice removes every thread's reservation on the evicted line and has no effect on other lines. A store-conditional in the same cycle as an eviction of its own line fails.
- R7: A new load-reserve from a thread replaces that thread's earlier reservation address.
- R8: In the cycle after a store-conditional, `res_valid` is high and `res_cr` holds the condition field {LT, GT, EQ, SO} in bits 3..0. LT and GT are 0, EQ is the pass result, and SO is `so_in` as sampled with the request. `res_valid` is low after any other operation.
- R9: A plain store always raises `wr_grant`. A load-reserve and an idle slot (`req_op`=0) never raise it.
- R10: Reservations of different threads are independent: a load-reserve or store-conditional from one thread never changes another thread's reservation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_op | input | 2 | 0 idle, 1 load-reserve, 2 store-conditional, 3 plain store |
| req_tid | input | TID_W | Issuing hardware thread |
| req_addr | input | ADDR_W | Byte address of the request |
| so_in | input | 1 | Summary-overflow bit to copy into the condition field |
| evict_valid | input | 1 | An eviction notice is present this cycle |
| evict_addr | input | ADDR_W | Any byte address inside the evicted line |
| wr_grant | output | 1 | The memory write for this cycle's store may proceed |
| res_valid | output | 1 | A store-conditional result is present |
| res_pass | output | 1 | The store-conditional passed |
| res_cr | output | 4 | Condition field {LT, GT, EQ, SO} |

## Verification
If a reservation slot holds the wrong validity or the wrong line tag, nothing appears at the ports until that thread issues a store-conditional. At that point `wr_grant` shows the wrong value in the same cycle, and `res_cr[1]` shows it one cycle later. A mistake in slot state can therefore stay hidden for many cycles. For this reason the bench follows every kind of reservation-clearing event with a store-conditional. It also keeps a cycle-accurate reference of all reservations and compares every grant and every result over a long mixed sweep of operations, threads, a few lines and evictions.

// File: rtl/lrsc_pkg.sv
// Shared definitions for the reservation monitor.
// Assumes: fixed 128-byte reservation granule.
package lrsc_pkg;
    localparam int LINE_BITS = 7;

    typedef enum logic [1:0] {
        OP_IDLE    = 2'd0,
        OP_LOADRSV = 2'd1,
        OP_STCOND  = 2'd2,
        OP_STORE   = 2'd3
    } op_e;
endpackage

// File: rtl/lrsc_rsv_slot.sv
// One thread's reservation: a valid flag plus a line tag.
// Assumes: take and drop both come from the snoop logic; take has priority.
module lrsc_rsv_slot #(
    parameter int TAG_W = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic             drop,
    input  logic [TAG_W-1:0] take_tag,
    output logic             held_valid,
    output logic [TAG_W-1:0] held_tag
);
    // Update the reservation state from the take/drop commands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_valid <= 1'b0;
            held_tag   <= '0;
        end else if (take) begin
            held_valid <= 1'b1;
            held_tag   <= take_tag;
        end else if (drop) begin
            held_valid <= 1'b0;
        end
    end

    assert_drop_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (drop && !take) |=> !held_valid);
    assert_take_replaces_R7: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (held_valid && held_tag == $past(take_tag)));
endmodule

// File: rtl/lrsc_snoop.sv
// Compares the request and eviction against every slot. Produces the
// take/drop command for each slot and the store-conditional verdict.
// Assumes: a thread number outside the thread range holds no reservation.
module lrsc_snoop
    import lrsc_pkg::*;
#(
    parameter int THREADS = 2,
    parameter int TID_W   = 1,
    parameter int TAG_W   = 25
) (
    input  op_e              op,
    input  logic [TID_W-1:0] tid,
    input  logic [TAG_W-1:0] req_tag,
    input  logic             evict_valid,
    input  logic [TAG_W-1:0] evict_tag,
    input  logic             held_valid [THREADS],
    input  logic [TAG_W-1:0] held_tag   [THREADS],
    output logic [THREADS-1:0] take,
    output logic [THREADS-1:0] drop,
    output logic             sc_pass
);
    logic is_sc;
    logic is_wr;
    logic evict_same;
    logic [THREADS-1:0] own_hit;

    assign is_sc      = (op == OP_STCOND);
    assign is_wr      = (op == OP_STCOND) || (op == OP_STORE);
    assign evict_same = evict_valid && (evict_tag == req_tag);

    for (genvar t = 0; t < THREADS; t++) begin : g_thr
        logic own;
        logic ev_hit;
        logic st_hit;
        assign own     = (tid == TID_W'(t));
        assign ev_hit  = evict_valid && held_valid[t] && (held_tag[t] == evict_tag);
        assign st_hit  = is_wr && !own && held_valid[t] && (held_tag[t] == req_tag);
        assign own_hit[t] = own && held_valid[t] && (held_tag[t] == req_tag);
        assign take[t] = own && (op == OP_LOADRSV);
        assign drop[t] = (own && is_sc) || ev_hit || st_hit;
    end

    // Verdict: the issuer holds this line and it is not being evicted now.
    always_comb begin
        sc_pass = is_sc && (|own_hit) && !evict_same;
    end
endmodule

// File: rtl/lrsc_result.sv
// Registers the store-conditional result and builds the condition field.
// Assumes: field bit order {LT, GT, EQ, SO} from bit 3 down to bit 0.
module lrsc_result (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sc_req,
    input  logic       sc_pass,
    input  logic       so_in,
    output logic       res_valid,
    output logic       res_pass,
    output logic [3:0] res_cr
);
    // Capture the verdict and summary-overflow for the following cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_pass  <= 1'b0;
            res_cr    <= 4'b0000;
        end else begin
            res_valid <= sc_req;
            res_pass  <= sc_req && sc_pass;
            res_cr    <= sc_req ? {2'b00, sc_pass, so_in} : 4'b0000;
        end
    end

    assert_cr_ltgt_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_cr[3:2] == 2'b00 && res_cr[1] == res_pass));
    assert_quiet_no_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (!res_pass && res_cr == 4'b0000));
endmodule

// File: rtl/lrsc_monitor.sv
// Top of the reservation monitor. It holds one reservation slot per hardware
// thread, snoops requests and evictions, grants store writes and reports the
// store-conditional results.
// Assumes: at most one request and one eviction per cycle.
module lrsc_monitor
    import lrsc_pkg::*;
#(
    parameter int THREADS = 2,
    parameter int ADDR_W  = 32,
    parameter int TID_W   = (THREADS > 1) ? $clog2(THREADS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        req_op,
    input  logic [TID_W-1:0]  req_tid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              so_in,
    input  logic              evict_valid,
    input  logic [ADDR_W-1:0] evict_addr,
    output logic              wr_grant,
    output logic              res_valid,
    output logic              res_pass,
    output logic [3:0]        res_cr
);
    localparam int TAG_W = ADDR_W - LINE_BITS;

    op_e                op;
    logic [TAG_W-1:0]   req_tag;
    logic [TAG_W-1:0]   evict_tag;
    logic               held_valid [THREADS];
    logic [TAG_W-1:0]   held_tag   [THREADS];
    logic [THREADS-1:0] take;
    logic [THREADS-1:0] drop;
    logic               sc_pass;
    logic               unused_line_offset;

    assign op        = op_e'(req_op);
    assign req_tag   = req_addr[ADDR_W-1:LINE_BITS];
    assign evict_tag = evict_addr[ADDR_W-1:LINE_BITS];
    assign unused_line_offset = ^{req_addr[LINE_BITS-1:0], evict_addr[LINE_BITS-1:0]};

    for (genvar t = 0; t < THREADS; t++) begin : g_slot
        lrsc_rsv_slot #(.TAG_W(TAG_W)) slot_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .take       (take[t]),
            .drop       (drop[t]),
            .take_tag   (req_tag),
            .held_valid (held_valid[t]),
            .held_tag   (held_tag[t])
        );
    end

    lrsc_snoop #(.THREADS(THREADS), .TID_W(TID_W), .TAG_W(TAG_W)) snoop_i (
        .op          (op),
        .tid         (req_tid),
        .req_tag     (req_tag),
        .evict_valid (evict_valid),
        .evict_tag   (evict_tag),
        .held_valid  (held_valid),
        .held_tag    (held_tag),
        .take        (take),
        .drop        (drop),
        .sc_pass     (sc_pass)
    );

    // Write permission: plain stores always, store-conditionals on a pass.
    always_comb begin
        wr_grant = (op == OP_STORE) || ((op == OP_STCOND) && sc_pass);
    end

    lrsc_result result_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sc_req    (op == OP_STCOND),
        .sc_pass   (sc_pass),
        .so_in     (so_in),
        .res_valid (res_valid),
        .res_pass  (res_pass),
        .res_cr    (res_cr)
    );

    assert_lr_no_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_LOADRSV || op == OP_IDLE) |-> !wr_grant);
    assert_grant_reports_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_STCOND && wr_grant) |=> (res_valid && res_pass));
    assert_fail_reports_fail_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_STCOND && !wr_grant) |=> (res_valid && !res_pass));
    assert_take_drop_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(take));
endmodule

// File: tb/lrsc_monitor_tb.sv
// Bench: directed cases per requirement, then a long mixed sweep that is
// compared against a reference model of the reservations kept in the bench.
module lrsc_monitor_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic [0:0]  req_tid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        so_in = 1'b0;
    logic        evict_valid = 1'b0;
    logic [31:0] evict_addr = '0;
    logic        wr_grant, res_valid, res_pass;
    logic [3:0]  res_cr;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    bit          mv [2];
    logic [24:0] ml [2];

    always #10 clk = ~clk;

    lrsc_monitor #(.THREADS(2), .ADDR_W(32)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_op(req_op), .req_tid(req_tid),
        .req_addr(req_addr), .so_in(so_in), .evict_valid(evict_valid),
        .evict_addr(evict_addr), .wr_grant(wr_grant), .res_valid(res_valid),
        .res_pass(res_pass), .res_cr(res_cr)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // One request cycle: drive, check the grant, then check the result and update the model.
    task automatic step(input logic [1:0] op, input int tid, input logic [31:0] addr,
                        input logic ev, input logic [31:0] eaddr, input logic so,
                        input string tag);
        logic [24:0] lt, et;
        bit pass, grant;
        bit nv [2];
        @(negedge clk);
        req_op = op; req_tid = tid[0:0]; req_addr = addr; so_in = so;
        evict_valid = ev; evict_addr = eaddr;
        lt = addr[31:7]; et = eaddr[31:7];
        pass  = (op == 2'd2) && mv[tid] && (ml[tid] == lt) && !(ev && et == lt);
        grant = (op == 2'd3) || pass;
        #2;
        chk(wr_grant == grant, tag, 32'(wr_grant), 32'(grant));
        for (int t = 0; t < 2; t++) begin
            nv[t] = mv[t];
            if (t == tid && op == 2'd1) begin
                nv[t] = 1'b1;
            end else if (t == tid && op == 2'd2) begin
                nv[t] = 1'b0;
            end else if (mv[t] && ((op[1] && t != tid && ml[t] == lt) || (ev && ml[t] == et))) begin
                nv[t] = 1'b0;
            end
        end
        @(posedge clk); #2;
        for (int t = 0; t < 2; t++) begin
            if (t == tid && op == 2'd1) ml[t] = lt;
            mv[t] = nv[t];
        end
        chk(res_valid == (op == 2'd2), {tag, "/R8 valid"}, 32'(res_valid), 32'(op == 2'd2));
        if (op == 2'd2) begin
            chk(res_cr == {2'b00, pass, so}, {tag, "/R8 cr"}, 32'(res_cr),
                32'({2'b00, pass, so}));
        end
    endtask

    task automatic idle_ev(input logic [31:0] eaddr, input string tag);
        step(2'd0, 0, 32'h0, 1'b1, eaddr, 1'b0, tag);
    endtask

    // Main stimulus.
    initial begin
        logic [15:0] lfsr;
        mv[0] = 0; mv[1] = 0; ml[0] = '0; ml[1] = '0;
        repeat (3) @(posedge clk);
        #2;
        chk(res_valid == 1'b0, "R1 reset res_valid", 32'(res_valid), 0);
        chk(wr_grant == 1'b0, "R1 reset grant", 32'(wr_grant), 0);
        @(negedge clk); rst_n = 1'b1;

        step(2'd2, 0, 32'h0000_0000, 0, 0, 0, "R1");
        step(2'd2, 1, 32'h0000_0000, 0, 0, 0, "R1");
        // R2: same line, different byte.
        step(2'd1, 0, 32'h0000_0100, 0, 0, 0, "R2");
        step(2'd2, 0, 32'h0000_017C, 0, 0, 0, "R2");
        // R4: a passed store-conditional consumes the reservation.
        step(2'd2, 0, 32'h0000_0100, 0, 0, 0, "R4");
        // R3 then R4: a failed one also consumes it.
        step(2'd1, 0, 32'h0000_0200, 0, 0, 0, "R3");
        step(2'd2, 0, 32'h0000_0280, 0, 0, 0, "R3");
        step(2'd2, 0, 32'h0000_0200, 0, 0, 0, "R4");
        step(2'd1, 0, 32'h8000_0100, 0, 0, 0, "R3");
        step(2'd2, 0, 32'h0000_0100, 0, 0, 0, "R3");
        // R5: stores from another thread, and from the owner.
        step(2'd1, 0, 32'h0000_0300, 0, 0, 0, "R5");
        step(2'd3, 1, 32'h0000_0340, 0, 0, 0, "R5");
        step(2'd2, 0, 32'h0000_0300, 0, 0, 0, "R5");
        step(2'd1, 0, 32'h0000_0300, 0, 0, 0, "R5");
        step(2'd3, 0, 32'h0000_0304, 0, 0, 0, "R5");
        step(2'd2, 0, 32'h0000_0300, 0, 0, 0, "R5");
        step(2'd1, 0, 32'h0000_0300, 0, 0, 0, "R5");
        step(2'd2, 1, 32'h0000_0300, 0, 0, 0, "R5");
        step(2'd2, 0, 32'h0000_0300, 0, 0, 0, "R5");
        // R6: evictions.
        step(2'd1, 0, 32'h0000_0400, 0, 0, 0, "R6");
        step(2'd1, 1, 32'h0000_0400, 0, 0, 0, "R6");
        idle_ev(32'h0000_0480, "R6");
        step(2'd2, 0, 32'h0000_0400, 0, 0, 0, "R6");
        idle_ev(32'h0000_047F, "R6");
        step(2'd2, 1, 32'h0000_0400, 0, 0, 0, "R6");
        step(2'd1, 0, 32'h0000_0500, 0, 0, 0, "R6");
        step(2'd2, 0, 32'h0000_0500, 1, 32'h0000_0520, 0, "R6");
        // R7: replacement of the reserved address.
        step(2'd1, 0, 32'h0000_0600, 0, 0, 0, "R7");
        step(2'd1, 0, 32'h0000_0700, 0, 0, 0, "R7");
        step(2'd2, 0, 32'h0000_0600, 0, 0, 0, "R7");
        step(2'd1, 0, 32'h0000_0600, 0, 0, 0, "R7");
        step(2'd1, 0, 32'h0000_0700, 0, 0, 0, "R7");
        step(2'd2, 0, 32'h0000_0700, 0, 0, 0, "R7");
        // R8: summary-overflow copied into the field.
        step(2'd1, 1, 32'h0000_0800, 0, 0, 0, "R8");
        step(2'd2, 1, 32'h0000_0800, 0, 0, 1, "R8");
        step(2'd2, 1, 32'h0000_0800, 0, 0, 1, "R8");
        // R9: plain store and idle.
        step(2'd3, 1, 32'h0000_0900, 0, 0, 0, "R9");
        step(2'd0, 1, 32'h0000_0900, 0, 0, 0, "R9");
        step(2'd1, 1, 32'h0000_0900, 0, 0, 0, "R9");
        // R10: independent threads.
        step(2'd1, 0, 32'h0000_0A00, 0, 0, 0, "R10");
        step(2'd1, 1, 32'h0000_0B00, 0, 0, 0, "R10");
        step(2'd2, 1, 32'h0000_0B00, 0, 0, 0, "R10");
        step(2'd2, 0, 32'h0000_0A00, 0, 0, 0, "R10");

        // Mixed sweep over two threads, eight lines and random evictions.
        lfsr = 16'hACE1;
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] a, e;
            logic [1:0]  op;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            op = lfsr[1:0];
            a  = {lfsr[2], 22'd0, lfsr[4:3], lfsr[9:5], 2'b00};
            e  = {lfsr[12], 22'd0, lfsr[14:13], 7'd5};
            step(op, int'(lfsr[10]), a, lfsr[11] & lfsr[15], e, lfsr[6],
                 "R2 sweep");
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: ends a hung run as a failure.
    initial begin
        #(20 * 150000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule